// File: doc/BRIEF.md
# Byte ALU with Five-Flag Status Register

This block is the arithmetic and logic datapath of a small accumulator machine. It takes an accumulator operand, a second operand and an operation code. It returns an 8-bit result in the same cycle, together with the value the status flags would take. The status word holds five flags: sign, zero, auxiliary (nibble) carry, parity and carry. It sits in a flop register that loads on the clock edge when the operation is marked valid.

Each operation has its own mask of flags it may write, and the other flags keep their stored values. This is how increment and decrement keep the carry, how complement leaves the status untouched, and how rotates and the carry-set/carry-toggle operations touch only carry. Carry-in, borrow-in and the decimal-adjust corrections read the stored flags.

A separate 16-bit pair adder always presents the sum of its two 16-bit inputs. When the pair-add operation is selected, its carry out is written into the carry flag only. Register storage, memory access and instruction decoding are outside this block.

Top module: `acc_alu_core`

## Requirements
- R1: `flags_q` holds {S,Z,AC,P,CY} in bits 4..0. It is cleared by the asynchronous active-low reset. It takes `flags_nxt` at a rising clock edge when `op_valid` is 1 and holds its value when `op_valid` is 0.
- R2: `op_sel` codes are: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 INC, 5 DEC, 6 AND, 7 OR, 8 XOR, 9 CMA, 10 CMP, 11 RLC, 12 RRC, 13 RAL, 14 RAR, 15 DAA, 16 STC, 17 CMC, 18 PAIR. `result` and `flags_nxt` are combinational. Any other code gives `result` = `opa` and `flags_nxt` = `flags_q`.
- R3: ADD/ADC give opa+opb(+CY); SUB/SBB give opa-opb(-CY). All five flags are written. For sums, CY is the carry out of bit 7 and AC is the carry out of bit 3. For differences, CY is the borrow out of bit 7 and AC is the borrow into bit 4.
- R4: Whenever an operation writes S, Z and P, they follow the value that sets the flags: S is bit 7, Z is 1 for 00h, and P is 1 when the number of one bits is even.
- R5: INC gives opa+1 and DEC gives opa-1. Both write S, Z, AC and P, and leave CY unchanged.
- R6: AND gives opa&opb, writes S, Z and P, sets AC to 1 and clears CY.
- R7: OR and XOR give opa|opb and opa^opb, write S, Z and P, and clear both AC and CY.
- R8: CMA gives ~opa and writes no flag.
- R9: CMP sets all five flags exactly as SUB on the same operands would, while `result` stays equal to `opa`.
- R10: RLC and RRC rotate opa left or right by one; the bit leaving the byte enters both CY and the opposite end. RAL and RAR rotate through carry: the old CY fills the vacated bit and the leaving bit becomes CY. Only CY is written.
- R11: DAA adds 06h when the low nibble of opa exceeds 9 or AC is set; AC becomes the carry out of bit 3 of that step. It then adds 60h when the high nibble exceeds 9, the step carried past bit 7, or CY is set; CY becomes 1 exactly when this upper step is taken. S, Z and P follow the adjusted value.
- R12: STC sets CY to 1 and CMC inverts CY. Both leave `result` = `opa` and write no other flag.
- R13: `pair_sum` is always (`pair_a`+`pair_b`) mod 2^16. PAIR writes only CY, with the carry out of bit 15, and leaves `result` = `opa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Commit the flag update of this cycle's operation |
| op_sel | input | 5 | Operation code |
| opa | input | DATA_W (8) | Accumulator operand |
| opb | input | DATA_W (8) | Second operand |
| pair_a | input | PAIR_W (16) | First register-pair operand |
| pair_b | input | PAIR_W (16) | Second register-pair operand |
| result | output | DATA_W (8) | Byte result |
| pair_sum | output | PAIR_W (16) | Register-pair sum |
| flags_nxt | output | 5 | Flag value the register would load |
| flags_q | output | 5 | Stored flags {S,Z,AC,P,CY} |

## Verification
`result`, `pair_sum` and `flags_nxt` are combinational, so they are due within the same cycle the operands are applied. The bench drives inputs on the falling edge and samples these outputs one time unit later. `flags_q` changes only at the next rising edge, so its check is made at the following falling edge. Because each table step inherits the flags left by the one before, carry-in, borrow-in and decimal-adjust behaviour are exercised through flags produced by the block itself.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W   = 5;
   localparam int FLAG_N = 5;

   // status word bit positions
   localparam int F_CY = 0;
   localparam int F_P  = 1;
   localparam int F_AC = 2;
   localparam int F_Z  = 3;
   localparam int F_S  = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBB  = 5'd3,
      OP_INC  = 5'd4,
      OP_DEC  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_CMA  = 5'd9,
      OP_CMP  = 5'd10,
      OP_RLC  = 5'd11,
      OP_RRC  = 5'd12,
      OP_RAL  = 5'd13,
      OP_RAR  = 5'd14,
      OP_DAA  = 5'd15,
      OP_STC  = 5'd16,
      OP_CMC  = 5'd17,
      OP_PAIR = 5'd18
   } alu_op_e;

   typedef logic [FLAG_N-1:0] flag_vec_t;

   localparam flag_vec_t WEN_ALL  = 5'b11111;
   localparam flag_vec_t WEN_NOCY = 5'b11110;
   localparam flag_vec_t WEN_CY   = 5'b00001;

endpackage

// File: rtl/acc_alu_addsub.sv
// Shared add / subtract unit with nibble carry (or borrow) output.
module acc_alu_addsub #(
   parameter int W     = 8,
   parameter int NIB_W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         half
);
   logic [W-1:0]     b_eff;
   logic             c_eff;
   logic [W:0]       full;
   logic [NIB_W:0]   low;

   always_comb begin
      b_eff = sub ? ~b : b;
      c_eff = sub ? ~cin : cin;
      full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
      low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
      sum   = full[W-1:0];
      // carry out inverted gives borrow when subtracting
      cout  = full[W] ^ sub;
      half  = low[NIB_W] ^ sub;
   end
endmodule

// File: rtl/acc_alu_rotate.sv
// One-position rotate, plain or through carry.
module acc_alu_rotate #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic         cin,
   input  logic [1:0]   mode,   // 0 left, 1 right, 2 left via carry, 3 right via carry
   output logic [W-1:0] y,
   output logic         cout
);
   always_comb begin
      unique case (mode)
         2'd0: begin y = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
         2'd1: begin y = {a[0], a[W-1:1]};   cout = a[0];   end
         2'd2: begin y = {a[W-2:0], cin};    cout = a[W-1]; end
         default: begin y = {cin, a[W-1:1]}; cout = a[0];   end
      endcase
   end
endmodule

// File: rtl/acc_alu_decadj.sv
// Two-digit BCD correction after a binary add.
module acc_alu_decadj #(
   parameter int W     = 8,
   parameter int NIB_W = 4
) (
   input  logic [W-1:0] a,
   input  logic         ac_in,
   input  logic         cy_in,
   output logic [W-1:0] y,
   output logic         ac_out,
   output logic         cy_out
);
   localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
   localparam logic [NIB_W:0]   FIX_LO    = (NIB_W+1)'(6);

   logic           lo_fix, hi_fix;
   logic [NIB_W:0] lo_sum;
   logic [W:0]     step1;
   logic [W:0]     step2;

   always_comb begin
      lo_fix = (a[NIB_W-1:0] > DIGIT_MAX) || ac_in;
      lo_sum = {1'b0, a[NIB_W-1:0]} + (lo_fix ? FIX_LO : '0);
      step1  = {1'b0, a} + {{(W-NIB_W){1'b0}}, (lo_fix ? FIX_LO : '0)};
      hi_fix = (step1[W-1:NIB_W] > DIGIT_MAX) || step1[W] || cy_in;
      step2  = {1'b0, step1[W-1:0]} + (hi_fix ? {1'b0, 4'd6, {NIB_W{1'b0}}} : '0);
      y      = step2[W-1:0];
      ac_out = lo_sum[NIB_W];
      cy_out = hi_fix;
   end
endmodule

// File: rtl/acc_alu_flagreg.sv
// Status register with one write enable per flag.
module acc_alu_flagreg #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] wen,
   input  logic [N-1:0] d,
   output logic [N-1:0] q,
   output logic [N-1:0] nxt
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                bit_q <= 1'b0;
         else if (load && wen[i])   bit_q <= d[i];
      end
      assign q[i]   = bit_q;
      assign nxt[i] = wen[i] ? d[i] : bit_q;
   end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAIR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [PAIR_W-1:0] pair_a,
   input  logic [PAIR_W-1:0] pair_b,
   output logic [DATA_W-1:0] result,
   output logic [PAIR_W-1:0] pair_sum,
   output logic [FLAG_N-1:0] flags_nxt,
   output logic [FLAG_N-1:0] flags_q
);
   localparam int NIB_W = 4;

   if (DATA_W != 2 * NIB_W) begin : g_bad_data_w
      $error("acc_alu_core: DATA_W must be two BCD digits wide (8)");
   end
   if (PAIR_W < DATA_W) begin : g_bad_pair_w
      $error("acc_alu_core: PAIR_W must not be narrower than DATA_W");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   // ---------------- add / subtract ----------------
   logic [DATA_W-1:0] add_b, add_sum;
   logic              add_cin, add_sub, add_cout, add_half;

   always_comb begin
      add_b   = opb;
      add_cin = 1'b0;
      add_sub = 1'b0;
      unique case (op)
         OP_ADC: add_cin = flags_q[F_CY];
         OP_SUB, OP_CMP: add_sub = 1'b1;
         OP_SBB: begin add_sub = 1'b1; add_cin = flags_q[F_CY]; end
         OP_INC: add_b = DATA_W'(1);
         OP_DEC: begin add_b = DATA_W'(1); add_sub = 1'b1; end
         default: ;
      endcase
   end

   acc_alu_addsub #(.W(DATA_W), .NIB_W(NIB_W)) u_addsub (
      .a(opa), .b(add_b), .cin(add_cin), .sub(add_sub),
      .sum(add_sum), .cout(add_cout), .half(add_half)
   );

   // ---------------- rotates ----------------
   logic [1:0]        rot_mode;
   logic [DATA_W-1:0] rot_y;
   logic              rot_c;

   always_comb begin
      unique case (op)
         OP_RRC:  rot_mode = 2'd1;
         OP_RAL:  rot_mode = 2'd2;
         OP_RAR:  rot_mode = 2'd3;
         default: rot_mode = 2'd0;
      endcase
   end

   acc_alu_rotate #(.W(DATA_W)) u_rotate (
      .a(opa), .cin(flags_q[F_CY]), .mode(rot_mode), .y(rot_y), .cout(rot_c)
   );

   // ---------------- decimal adjust ----------------
   logic [DATA_W-1:0] da_y;
   logic              da_ac, da_cy;

   acc_alu_decadj #(.W(DATA_W), .NIB_W(NIB_W)) u_decadj (
      .a(opa), .ac_in(flags_q[F_AC]), .cy_in(flags_q[F_CY]),
      .y(da_y), .ac_out(da_ac), .cy_out(da_cy)
   );

   // ---------------- register-pair adder ----------------
   logic [PAIR_W:0] pair_full;
   logic            pair_c;
   assign pair_full = {1'b0, pair_a} + {1'b0, pair_b};
   assign pair_sum  = pair_full[PAIR_W-1:0];
   assign pair_c    = pair_full[PAIR_W];

   // ---------------- result and flag selection ----------------
   logic [DATA_W-1:0] res, szp_src;
   flag_vec_t         fd, wen;

   always_comb begin
      res = opa;
      fd  = '0;
      wen = '0;
      unique case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            res = add_sum; wen = WEN_ALL;
            fd[F_CY] = add_cout; fd[F_AC] = add_half;
         end
         OP_CMP: begin
            wen = WEN_ALL;
            fd[F_CY] = add_cout; fd[F_AC] = add_half;
         end
         OP_INC, OP_DEC: begin
            res = add_sum; wen = WEN_NOCY; fd[F_AC] = add_half;
         end
         OP_AND: begin
            res = opa & opb; wen = WEN_ALL; fd[F_AC] = 1'b1;
         end
         OP_OR:  begin res = opa | opb; wen = WEN_ALL; end
         OP_XOR: begin res = opa ^ opb; wen = WEN_ALL; end
         OP_CMA: res = ~opa;
         OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
            res = rot_y; wen = WEN_CY; fd[F_CY] = rot_c;
         end
         OP_DAA: begin
            res = da_y; wen = WEN_ALL;
            fd[F_AC] = da_ac; fd[F_CY] = da_cy;
         end
         OP_STC:  begin wen = WEN_CY; fd[F_CY] = 1'b1; end
         OP_CMC:  begin wen = WEN_CY; fd[F_CY] = ~flags_q[F_CY]; end
         OP_PAIR: begin wen = WEN_CY; fd[F_CY] = pair_c; end
         default: ;
      endcase
      szp_src  = (op == OP_CMP) ? add_sum : res;
      fd[F_S]  = szp_src[DATA_W-1];
      fd[F_Z]  = (szp_src == '0);
      fd[F_P]  = ~^szp_src;
   end

   assign result = res;

   acc_alu_flagreg #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .load(op_valid),
      .wen(wen), .d(fd), .q(flags_q), .nxt(flags_nxt)
   );

endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [OP_W-1:0]   op_sel,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] result,
   input logic [FLAG_N-1:0] flags_q
);
   // R1
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flags_q));

   // R4
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_INC ||
                   op_sel == OP_DEC || op_sel == OP_AND || op_sel == OP_XOR ||
                   op_sel == OP_DAA)
      |=> flags_q[F_Z] == ($past(result) == '0));

   // R5
   incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_sel == OP_INC || op_sel == OP_DEC)
      |=> flags_q[F_CY] == $past(flags_q[F_CY]));

   // R6
   and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_sel == OP_AND |=> flags_q[F_AC] && !flags_q[F_CY]);

   // R7
   orxor_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_sel == OP_OR || op_sel == OP_XOR)
      |=> !flags_q[F_AC] && !flags_q[F_CY]);

   // R8
   cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_sel == OP_CMA |=> $stable(flags_q));

   // R9
   cmp_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_sel == OP_CMP |-> result == opa);

   // R10 R12 R13
   carry_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_sel == OP_RLC || op_sel == OP_RRC || op_sel == OP_RAL ||
                   op_sel == OP_RAR || op_sel == OP_STC || op_sel == OP_CMC ||
                   op_sel == OP_PAIR)
      |=> flags_q[FLAG_N-1:1] == $past(flags_q[FLAG_N-1:1]));
endmodule

bind acc_alu_core acc_alu_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
   .opa(opa), .result(result), .flags_q(flags_q)
);

// File: tb/acc_alu_core_test.sv
module acc_alu_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_sel = 5'd0;
   logic [7:0]  opa = 8'h00, opb = 8'h00;
   logic [15:0] pair_a = 16'h0, pair_b = 16'h0;
   logic [7:0]  result;
   logic [15:0] pair_sum;
   logic [4:0]  flags_nxt, flags_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu_core uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opa(opa), .opb(opb), .pair_a(pair_a), .pair_b(pair_b),
      .result(result), .pair_sum(pair_sum), .flags_nxt(flags_nxt), .flags_q(flags_q)
   );

   // {op, opa, opb, expected result, expected flags S Z AC P CY}; flags carry over
   localparam logic [33:0] VEC [NV] = '{
      {5'd0,  8'h9A, 8'h89, 8'h23, 5'b00101},
      {5'd1,  8'h9A, 8'h89, 8'h24, 5'b00111},
      {5'd2,  8'h05, 8'h13, 8'hF2, 5'b10001},
      {5'd4,  8'hFF, 8'h00, 8'h00, 5'b01111},
      {5'd5,  8'h00, 8'h00, 8'hFF, 5'b10111},
      {5'd3,  8'h40, 8'h20, 8'h1F, 5'b00100},
      {5'd6,  8'h62, 8'h4A, 8'h42, 5'b00110},
      {5'd6,  8'h62, 8'h15, 8'h00, 5'b01110},
      {5'd7,  8'h62, 8'h4A, 8'h6A, 5'b00010},
      {5'd8,  8'hEE, 8'h5A, 8'hB4, 5'b10010},
      {5'd9,  8'h9A, 8'h00, 8'h65, 5'b10010},
      {5'd10, 8'h20, 8'h08, 8'h20, 5'b00110},
      {5'd10, 8'h05, 8'h13, 8'h05, 5'b10001},
      {5'd11, 8'h01, 8'h00, 8'h02, 5'b10000},
      {5'd13, 8'h80, 8'h00, 8'h00, 5'b10001},
      {5'd14, 8'h02, 8'h00, 8'h81, 5'b10000},
      {5'd12, 8'h01, 8'h00, 8'h80, 5'b10001},
      {5'd17, 8'h5A, 8'h00, 8'h5A, 5'b10000},
      {5'd16, 8'h5A, 8'h00, 8'h5A, 5'b10001},
      {5'd0,  8'h38, 8'h34, 8'h6C, 5'b00010},
      {5'd15, 8'h6C, 8'h00, 8'h72, 5'b00110},
      {5'd0,  8'h09, 8'h09, 8'h12, 5'b00110},
      {5'd15, 8'h12, 8'h00, 8'h18, 5'b00010},
      {5'd0,  8'h90, 8'h90, 8'h20, 5'b00001},
      {5'd15, 8'h20, 8'h00, 8'h80, 5'b10001},
      {5'd0,  8'h99, 8'h01, 8'h9A, 5'b10010},
      {5'd15, 8'h9A, 8'h00, 8'h00, 5'b01111},
      {5'd2,  8'h13, 8'h13, 8'h00, 5'b01010}
   };

   function automatic string req_of(input logic [4:0] op);
      case (op)
         5'd0, 5'd1, 5'd2, 5'd3: return "R3";
         5'd4, 5'd5:             return "R5";
         5'd6:                   return "R6";
         5'd7, 5'd8:             return "R7";
         5'd9:                   return "R8";
         5'd10:                  return "R9";
         5'd15:                  return "R11";
         5'd16, 5'd17:           return "R12";
         default:                return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic v);
      @(negedge clk);
      op_sel = op; opa = a; opb = b; op_valid = v;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset flags", {11'd0, flags_q}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags after reset release", {11'd0, flags_q}, 16'h0000);

      // table walk: combinational outputs, then registered flags
      for (int i = 0; i < NV; i++) begin
         logic [33:0] v;
         v = VEC[i];
         drive(v[33:29], v[28:21], v[20:13], 1'b1);
         check({req_of(v[33:29]), " result"}, {8'h00, result}, {8'h00, v[12:5]});
         check({req_of(v[33:29]), " R4 flags_nxt"}, {11'd0, flags_nxt}, {11'd0, v[4:0]});
         @(negedge clk);
         check({req_of(v[33:29]), " R4 flags_q"}, {11'd0, flags_q}, {11'd0, v[4:0]});
      end
      // flags now 01010

      // R1: op_valid low, no flag load
      drive(5'd0, 8'h9A, 8'h89, 1'b0);
      check("R1 comb result while idle", {8'h00, result}, 16'h0023);
      check("R1 flags_nxt while idle", {11'd0, flags_nxt}, 16'h0005);
      @(negedge clk);
      check("R1 flags held", {11'd0, flags_q}, 16'h000A);

      // R2: unassigned code
      drive(5'd25, 8'h3C, 8'hC3, 1'b1);
      check("R2 unused code result", {8'h00, result}, 16'h003C);
      check("R2 unused code flags_nxt", {11'd0, flags_nxt}, 16'h000A);
      @(negedge clk);
      check("R2 unused code flags_q", {11'd0, flags_q}, 16'h000A);

      // R13: pair add without carry
      pair_a = 16'h2233; pair_b = 16'h1122;
      drive(5'd18, 8'h77, 8'h00, 1'b1);
      check("R13 pair sum", pair_sum, 16'h3355);
      check("R13 pair result", {8'h00, result}, 16'h0077);
      @(negedge clk);
      check("R13 pair no carry", {11'd0, flags_q}, 16'h000A);
      // R13: pair add with carry out
      pair_a = 16'hFFFF; pair_b = 16'h0001;
      drive(5'd18, 8'h77, 8'h00, 1'b1);
      check("R13 pair wrap sum", pair_sum, 16'h0000);
      @(negedge clk);
      check("R13 pair carry only", {11'd0, flags_q}, 16'h000B);

      // R3: borrow in through zero
      drive(5'd3, 8'h00, 8'h00, 1'b1);
      check("R3 sbb borrow result", {8'h00, result}, 16'h00FF);
      @(negedge clk);
      check("R3 sbb borrow flags", {11'd0, flags_q}, 16'h0017);

      // R1: asynchronous reset mid-run
      op_valid = 1'b0;
      #2 rst_n = 1'b0;
      #1;
      check("R1 async reset clears", {11'd0, flags_q}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule